// File: doc/BRIEF.md
# Double to Int32 Wrapping Converter

This unit takes a 64-bit double-precision operand and turns it into a signed 32-bit integer. It always rounds toward zero. When the truncated value does not fit in 32 bits it does not clamp. It keeps the low 32 bits of the exact truncated two's-complement integer, so the value wraps modulo 2^32. Infinities and NaNs become zero. The 32-bit result is sign-extended into a 64-bit output word.

The unit also reports two flags. The invalid flag marks a special input or a finite value outside the signed 32-bit range. The inexact flag marks a dropped fraction on an in-range finite value. The unit is meant for runtimes that need integer truncation modulo 2^32 of double values. Operands enter with a valid strobe, and the result and flags appear, marked valid, exactly one clock later. An operand can be accepted on every cycle.

Top module: `dcvt_mod32`

## Requirements
- R1: A finite operand whose truncated value lies in [-2^31, 2^31-1] gives that truncated value, rounded toward zero, as the result.
- R2: A finite operand outside that range gives the low 32 bits of the two's complement of its exact truncated value. For example, 2^32+5 gives 5 and -(2^32+5) gives -5.
- R3: Result bits 63:32 always equal result bit 31.
- R4: Infinities of either sign and every NaN (exponent field bits 62:52 all ones) give result 0 with invalid set and inexact clear.
- R5: A finite operand with unbiased exponent of 84 or more gives result 0, with invalid set. Unbiased exponent 83 with the lowest significand bit set gives 0xFFFFFFFF80000000.
- R6: Invalid (out_flags bit 1) is set for a finite operand exactly when its truncated value is outside [-2^31, 2^31-1]. -2^31 is in range and 2^31 is not.
- R7: Inexact (out_flags bit 0) is set only for a finite, in-range operand with a nonzero fractional part. It is never set together with invalid.
- R8: An operand with magnitude below 1, including subnormals, gives result 0 with invalid clear. Inexact is set unless the operand is +0 or -0.
- R9: out_valid is high exactly one cycle after in_valid is high. When in_valid is low, result and out_flags hold their previous values.
- R10: After reset, out_valid, result and out_flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| operand | input | 64 | Double-precision input value |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 64 | Wrapped int32, sign-extended to 64 bits |
| out_flags | output | 2 | Bit 1 invalid, bit 0 inexact |

## Verification
Wraparound and the invalid flag fall in the same output cycle for every out-of-range finite operand. The bench provokes this with values just past ±2^31, with 2^32+5 and its negative, and with huge exponents up to and beyond 84. It judges the wrapped low bits and the invalid bit together against a reference that shifts the significand in a 128-bit word. Fraction loss and range overflow can also coincide, for example at 2^31+0.5. In that case the bench confirms that invalid wins and inexact stays clear. A full sweep of every exponent value, for both signs and several significand patterns, is fed back to back so that the one-cycle latency is checked on every result.

// File: rtl/dcvt_pkg.sv
package dcvt_pkg;

    typedef struct packed {
        logic invalid;
        logic inexact;
    } dcvt_flags_t;

    typedef enum logic [1:0] {
        K_SPECIAL = 2'd0,
        K_SMALL   = 2'd1,
        K_INT     = 2'd2
    } dcvt_kind_e;

endpackage

// File: rtl/dcvt_classify.sv
module dcvt_classify
    import dcvt_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] operand,
    output dcvt_kind_e            kind,
    output logic                  sign,
    output logic                  nonzero,
    output logic [FRAC_W:0]       mant,
    output logic [EXP_W-1:0]      ue
);
    localparam int FP_W = 1 + EXP_W + FRAC_W;
    localparam logic [EXP_W-1:0] BIAS_E = {1'b0, {(EXP_W-1){1'b1}}};

    logic [EXP_W-1:0] exp_f;

    always_comb begin
        exp_f   = operand[FRAC_W +: EXP_W];
        sign    = operand[FP_W-1];
        nonzero = |operand[FP_W-2:0];
        mant    = {|exp_f, operand[FRAC_W-1:0]};
        ue      = exp_f - BIAS_E;
        if (&exp_f)
            kind = K_SPECIAL;
        else if (exp_f < BIAS_E)
            kind = K_SMALL;
        else
            kind = K_INT;
    end
endmodule

// File: rtl/dcvt_align.sv
module dcvt_align #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 32
) (
    input  logic [FRAC_W:0]  mant,
    input  logic [EXP_W-1:0] ue,
    input  logic             sign,
    output logic [INT_W-1:0] mag_lo,
    output logic             frac_nz,
    output logic             out_of_range
);
    localparam int MW = FRAC_W + 1;
    localparam logic [EXP_W-1:0] FRAC_E = EXP_W'(FRAC_W);
    localparam logic [EXP_W-1:0] INT_E  = EXP_W'(INT_W);
    localparam logic [EXP_W-1:0] TOP_E  = EXP_W'(INT_W - 1);
    localparam logic [INT_W-1:0] MIN_MAG = {1'b1, {(INT_W-1){1'b0}}};

    logic [EXP_W-1:0] rsh;
    logic [EXP_W-1:0] lsh;
    logic [MW-1:0]    lost_mask;

    always_comb begin
        rsh       = '0;
        lsh       = '0;
        lost_mask = '0;
        mag_lo    = '0;
        if (ue <= FRAC_E) begin
            // binary point inside the significand: drop the fraction
            rsh       = FRAC_E - ue;
            mag_lo    = INT_W'(mant >> rsh);
            lost_mask = ~({MW{1'b1}} << rsh);
        end else begin
            // integer grows past the significand: only low bits survive
            lsh = ue - FRAC_E;
            if (lsh < INT_E)
                mag_lo = INT_W'(mant << lsh);
        end
        frac_nz = |(mant & lost_mask);
        if (ue > TOP_E)
            out_of_range = 1'b1;
        else if (ue == TOP_E)
            out_of_range = !(sign && (mag_lo == MIN_MAG));
        else
            out_of_range = 1'b0;
    end
endmodule

// File: rtl/dcvt_mod32.sv
module dcvt_mod32
    import dcvt_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 32,
    parameter int OUT_W  = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [EXP_W+FRAC_W:0]     operand,
    output logic                      out_valid,
    output logic [OUT_W-1:0]          result,
    output logic [1:0]                out_flags
);
    localparam int EXT_W = OUT_W - INT_W;
    localparam logic [EXP_W-1:0] BIAS_E = {1'b0, {(EXP_W-1){1'b1}}};
    localparam logic [EXP_W-1:0] HUGE_E = BIAS_E + EXP_W'(INT_W + FRAC_W);
    localparam logic [EXP_W-1:0] SAFE_E = BIAS_E + EXP_W'(INT_W - 1);

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] res;
        dcvt_flags_t      flg;
    } state_t;

    state_t st_d, st_q;

    dcvt_kind_e       kind;
    logic             sign;
    logic             nonzero;
    logic [FRAC_W:0]  mant;
    logic [EXP_W-1:0] ue;
    logic [INT_W-1:0] mag_lo;
    logic             frac_nz;
    logic             oor;
    logic [INT_W-1:0] lo_d;

    dcvt_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .operand (operand),
        .kind    (kind),
        .sign    (sign),
        .nonzero (nonzero),
        .mant    (mant),
        .ue      (ue)
    );

    dcvt_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
        .mant         (mant),
        .ue           (ue),
        .sign         (sign),
        .mag_lo       (mag_lo),
        .frac_nz      (frac_nz),
        .out_of_range (oor)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        lo_d     = sign ? (INT_W'(0) - mag_lo) : mag_lo;
        if (in_valid) begin
            unique case (kind)
                K_SPECIAL: begin
                    st_d.res = '0;
                    st_d.flg = '{invalid: 1'b1, inexact: 1'b0};
                end
                K_SMALL: begin
                    st_d.res = '0;
                    st_d.flg = '{invalid: 1'b0, inexact: nonzero};
                end
                default: begin
                    st_d.res = {{EXT_W{lo_d[INT_W-1]}}, lo_d};
                    st_d.flg = '{invalid: oor, inexact: !oor && frac_nz};
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign out_flags = st_q.flg;

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(out_flags)));
    p_special_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&operand[FRAC_W +: EXP_W])) |=> (result == '0 && out_flags == 2'b10));
    p_huge_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && operand[FRAC_W +: EXP_W] >= HUGE_E) |=> (result == '0 && out_flags[1]));
    p_small_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && operand[FRAC_W +: EXP_W] < BIAS_E) |=> (result == '0 && !out_flags[1]));
    p_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && operand[FRAC_W +: EXP_W] >= BIAS_E && operand[FRAC_W +: EXP_W] < SAFE_E)
        |=> (!out_flags[1] && result[OUT_W-1] == $past(operand[EXP_W+FRAC_W])));
    p_flag_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_flags[1] && out_flags[0]));
    p_sign_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (result[OUT_W-1:INT_W] == {EXT_W{result[INT_W-1]}}));
endmodule

// File: tb/dcvt_mod32_tb.sv
module dcvt_mod32_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] operand;
    logic        out_valid;
    logic [63:0] result;
    logic [1:0]  out_flags;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dcvt_mod32 u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .operand   (operand),
        .out_valid (out_valid),
        .result    (result),
        .out_flags (out_flags)
    );

    function automatic logic [63:0] mk(input logic s, input int e, input logic [51:0] f);
        return {s, 11'(e), f};
    endfunction

    // reference: shift significand into a wide word, compare against bounds
    function automatic logic [65:0] ref_model(input logic [63:0] x);
        logic        s;
        int          e, ue;
        logic [127:0] mant, full, lostm;
        logic        oor, fr;
        logic [31:0] low, val;
        s = x[63];
        e = int'(x[62:52]);
        if (e == 2047) return {64'd0, 2'b10};
        if (e < 1023) return {64'd0, 1'b0, |x[62:0]};
        ue   = e - 1023;
        mant = {75'd0, 1'b1, x[51:0]};
        fr   = 1'b0;
        if (ue >= 120) begin
            full = 128'd0;
            oor  = 1'b1;
        end else begin
            if (ue <= 52) begin
                full  = mant >> (52 - ue);
                lostm = (128'd1 << (52 - ue)) - 128'd1;
                fr    = |(mant & lostm);
            end else begin
                full = mant << (ue - 52);
            end
            oor = s ? (full > 128'h8000_0000) : (full > 128'h7FFF_FFFF);
        end
        low = full[31:0];
        val = s ? (32'd0 - low) : low;
        return {{32{val[31]}}, val, oor, !oor && fr};
    endfunction

    task automatic chk(input string req, input logic [63:0] x,
                       input logic [63:0] exp_res, input logic [1:0] exp_flg);
        checks++;
        if (!out_valid || result !== exp_res || out_flags !== exp_flg) begin
            failures++;
            $display("FAIL %s op=%h actual res=%h flg=%b vld=%b expected res=%h flg=%b vld=1",
                     req, x, result, out_flags, out_valid, exp_res, exp_flg);
        end
    endtask

    // one vector: drive, let it register, check
    task automatic one(input string req, input logic [63:0] x,
                       input logic [63:0] exp_res, input logic [1:0] exp_flg);
        @(negedge clk);
        in_valid = 1'b1;
        operand  = x;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, x, exp_res, exp_flg);
    endtask

    function automatic string tag_of(input logic [63:0] x, input logic [1:0] fl);
        int e;
        e = int'(x[62:52]);
        if (e == 2047) return "R4";
        if (e < 1023) return "R8";
        if (e >= 1023 + 84) return "R5";
        if (fl[1]) return "R2";
        return "R1";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] prev_x;
        logic [65:0] prev_r;
        logic        have_prev;
        logic [63:0] held_res;
        logic [1:0]  held_flg;
        logic [51:0] pats [5];
        rst_n    = 1'b0;
        in_valid = 1'b0;
        operand  = 64'h3FF8_0000_0000_0000;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 64'd0 || out_flags !== 2'b00) begin
            failures++;
            $display("FAIL R10 actual vld=%b res=%h flg=%b expected 0 0 00", out_valid, result, out_flags);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 64'd0 || out_flags !== 2'b00) begin
            failures++;
            $display("FAIL R10 after release actual vld=%b res=%h flg=%b expected 0 0 00", out_valid, result, out_flags);
        end

        // directed corner values
        one("R7 1.5", 64'h3FF8_0000_0000_0000, 64'd1, 2'b01);
        one("R1 R3 -1.5", 64'hBFF8_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01);
        one("R6 R2 R3 +2^31", 64'h41E0_0000_0000_0000, 64'hFFFF_FFFF_8000_0000, 2'b10);
        one("R6 -2^31", 64'hC1E0_0000_0000_0000, 64'hFFFF_FFFF_8000_0000, 2'b00);
        one("R6 2^31-1", 64'h41DF_FFFF_FFC0_0000, 64'h0000_0000_7FFF_FFFF, 2'b00);
        one("R7 R6 2^31+0.5", 64'h41E0_0000_0010_0000, 64'hFFFF_FFFF_8000_0000, 2'b10);
        one("R2 2^32+5", 64'h41F0_0000_0050_0000, 64'd5, 2'b10);
        one("R2 -(2^32+5)", 64'hC1F0_0000_0050_0000, 64'hFFFF_FFFF_FFFF_FFFB, 2'b10);
        one("R5 ue83", mk(1'b0, 1023 + 83, 52'd1), 64'hFFFF_FFFF_8000_0000, 2'b10);
        one("R5 ue84", mk(1'b0, 1023 + 84, 52'd1), 64'd0, 2'b10);
        one("R4 +inf", 64'h7FF0_0000_0000_0000, 64'd0, 2'b10);
        one("R4 -inf", 64'hFFF0_0000_0000_0000, 64'd0, 2'b10);
        one("R4 nan", 64'hFFF8_0000_0000_0001, 64'd0, 2'b10);
        one("R8 subnormal", 64'h0000_0000_0000_0001, 64'd0, 2'b01);
        one("R8 -0", 64'h8000_0000_0000_0000, 64'd0, 2'b00);
        one("R8 -0.75", 64'hBFE8_0000_0000_0000, 64'd0, 2'b01);

        // hold while idle
        held_res = result;
        held_flg = out_flags;
        @(negedge clk);
        operand = 64'h4059_0000_0000_0000;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== held_res || out_flags !== held_flg) begin
            failures++;
            $display("FAIL R9 hold actual vld=%b res=%h flg=%b expected 0 %h %b",
                     out_valid, result, out_flags, held_res, held_flg);
        end

        // back-to-back sweep over every exponent
        pats[0] = 52'h0;
        pats[1] = 52'h8_0000_0000_0000;
        pats[2] = 52'h0_0000_0000_0001;
        pats[3] = 52'hF_FFFF_FFFF_FFFF;
        pats[4] = 52'h5_A5A5_A5A5_A5A5;
        have_prev = 1'b0;
        prev_x = '0;
        prev_r = '0;
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 5; p++) begin
                for (int e = 0; e < 2048; e++) begin
                    @(negedge clk);
                    if (have_prev)
                        chk({tag_of(prev_x, prev_r[1:0]), " R9 sweep"}, prev_x, prev_r[65:2], prev_r[1:0]);
                    prev_x    = mk(s[0], e, pats[p]);
                    prev_r    = ref_model(prev_x);
                    have_prev = 1'b1;
                    in_valid  = 1'b1;
                    operand   = prev_x;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag_of(prev_x, prev_r[1:0]), " sweep last"}, prev_x, prev_r[65:2], prev_r[1:0]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule